// File: doc/BRIEF.md
# Dual Programmable PN Code Generator

This block produces the spreading codes for a time-division duplex spread-spectrum link. It contains two linear feedback shift register generators, one for the transmit direction and one for the receive direction. Each has up to 13 stages, its own feedback tap word and its own length mask. Every sequence is stretched by one state so that its period is an exact power of two, from 128 to 8192 chips.

The transmit generator and the receive generator step on chip enables. When the block is the link master, the transmit generator steps on an internal strobe that fires once every 16 master clocks, and the receive generator follows an external phase-controlled enable. When the block is the slave, both generators follow the external enable. One registered code output carries the transmit chips during the transmit half of the TDD cycle and the receive chips during the receive half. A pad-enable output drops for one master clock at every change of the code value, so the pad rests at mid-rail during each transition. Each generator also flags the start of its sequence (the epoch).

Top module: `dual_pn_gen`

## Requirements
- R1: While reset is asserted, code_out and code_oe are 0, both generator states equal 1 and both epoch outputs are 1. The latched tap words and latched length masks are zero.
- R2: In master mode (is_master=1) the transmit generator advances only on an internal strobe that is high on the 16th master clock after reset and on every 16th clock after that. In slave mode it advances only on cycles where ext_chip_en is 1. The state does not change on any other cycle.
- R3: The receive generator advances only on cycles where ext_chip_en is 1, in both modes.
- R4: One step shifts the state up by one bit and writes the feedback into bit 0. The feedback is the XOR of the state bits selected by the tap word, where tap k (1..13) is state bit k-1. Taps 1..8 come from the low tap byte and taps 9..13 from bits 0..4 of the high tap field. Tapped bits above the active length are ignored. code chip = state bit 0.
- R5: Length mask bit i enables state bit 5+i, and bits 0..4 are always active. Masks 0x03, 0x07, 0x0F, 0x1F, 0x3F, 0x7F and 0xFF give 7 to 13 active stages (n). When all active bits below the top active bit are zero, the feedback is inverted. As a result the all-zero state occurs once and the period with primitive taps is exactly 2^n chips.
- R6: Tap words and length masks take effect only on a cycle where force_load is 1. At other times a change on those inputs leaves the code unaltered. The step taken on the force_load cycle still uses the previous taps.
- R7: On a cycle where resync is 1, both generators are set to state 1, and this overrides any step.
- R8: On each clock, code_out is updated to the transmit chip when tx_half is 1 and to the receive chip when tx_half is 0, with a latency of one clock.
- R9: On each clock where out_en is 0, code_out is updated to 0.
- R10: code_oe is 0 for exactly the first clock in which code_out holds a new value, and is 1 while code_out is unchanged.
- R11: tx_epoch and rx_epoch are 1 while the active part of their generator's state equals 1, which is the first state of the sequence. This lasts one chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1 = this end initiates the link |
| ext_chip_en | input | 1 | Phase-controlled chip enable |
| tx_half | input | 1 | 1 = transmit half of the TDD cycle |
| out_en | input | 1 | Code output enable |
| force_load | input | 1 | Latch tap words and length masks |
| resync | input | 1 | Set both generators to the start state |
| tx_tap_lo | input | 8 | Transmit taps 1..8 |
| tx_tap_hi | input | 5 | Transmit taps 9..13 |
| tx_len_mask | input | 8 | Transmit length mask |
| rx_tap_lo | input | 8 | Receive taps 1..8 |
| rx_tap_hi | input | 5 | Receive taps 9..13 |
| rx_len_mask | input | 8 | Receive length mask |
| code_out | output | 1 | Multiplexed code chip |
| code_oe | output | 1 | Pad drive enable for code_out |
| tx_epoch | output | 1 | Transmit sequence start flag |
| rx_epoch | output | 1 | Receive sequence start flag |

## Verification
The bench measures the spacing of epoch rises at the shortest length (2048 clocks in master mode) and at the longest length (8192 clocks with an enable on every clock). A generator that skipped the extra all-zero state, or that locked up in it, would give a wrong spacing or no epoch at all. Tap inputs are changed without force_load, and the code stream is compared against an independent model. A design that reacted to live tap inputs, or that used the new taps on the load cycle itself, would then diverge. Bursts of consecutive chip changes check that code_oe drops for exactly one clock after every change and never during a run of equal chips. Checks with out_en low and with resync cover a mux that leaks chips while disabled and a resync that leaves the two generators misaligned.

// File: rtl/pngen_pkg.sv
package pngen_pkg;
  localparam int unsigned PN_STAGES = 13;
  localparam int unsigned PN_FIXED  = 5;
  localparam int unsigned PN_MASK_W = PN_STAGES - PN_FIXED;
  localparam int unsigned TAP_LO_W  = 8;
  localparam int unsigned TAP_HI_W  = PN_STAGES - TAP_LO_W;

  typedef logic [PN_STAGES-1:0] pn_word_t;

  // Active stage bits: low stages always on, upper ones from the mask.
  function automatic pn_word_t pn_active(input logic [PN_MASK_W-1:0] mask);
    return {mask, {PN_FIXED{1'b1}}};
  endfunction

  // One step: shift up, feedback into bit 0, invert when the active bits
  // below the top one are all zero so the all-zero state is visited once.
  function automatic pn_word_t pn_step(input pn_word_t st, input pn_word_t taps,
                                       input pn_word_t act);
    logic fb;
    logic low_zero;
    fb       = ^(st & taps & act);
    low_zero = ((st & (act >> 1)) == '0);
    return {st[PN_STAGES-2:0], fb ^ low_zero} & act;
  endfunction

  function automatic logic pn_at_epoch(input pn_word_t st, input pn_word_t act);
    return ((st & act) == pn_word_t'(1));
  endfunction
endpackage

// File: rtl/pn_chip_div.sv
module pn_chip_div #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign stb = (cnt == LAST);

  // R2: strobe never lasts two clocks
  p_stb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
endmodule

// File: rtl/pn_lfsr.sv
module pn_lfsr
  import pngen_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 resync,
  input  logic                 force_load,
  input  pn_word_t             tap_in,
  input  logic [PN_MASK_W-1:0] mask_in,
  output logic                 chip,
  output logic                 epoch
);
  pn_word_t             state;
  pn_word_t             taps_q;
  logic [PN_MASK_W-1:0] mask_q;
  pn_word_t             act;
  pn_word_t             step_val;
  logic                 state_zero;

  assign act        = pn_active(mask_q);
  assign step_val   = pn_step(state, taps_q, act);
  assign state_zero = ((state & act) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= pn_word_t'(1);
    else if (resync) state <= pn_word_t'(1);
    else if (adv)    state <= step_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_q <= '0;
      mask_q <= '0;
    end else if (force_load) begin
      taps_q <= tap_in;
      mask_q <= mask_in;
    end
  end

  assign chip  = state[0];
  assign epoch = pn_at_epoch(state, act);

  // R7: resync lands on the start state
  p_resync_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (state == pn_word_t'(1)));
  // R2/R3: no step without an enable
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !resync) |=> $stable(state));
  // R5: the all-zero state exits to the start state
  p_zero_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !resync && state_zero) |=> (state == pn_word_t'(1)));
  // R6: latched taps move only on force_load
  p_taps_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !force_load |=> ($stable(taps_q) && $stable(mask_q)));
endmodule

// File: rtl/pn_out_mux.sv
module pn_out_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_half,
  input  logic out_en,
  input  logic tx_chip,
  input  logic rx_chip,
  output logic code_out,
  output logic code_oe
);
  logic nxt_code;

  assign nxt_code = out_en ? (tx_half ? tx_chip : rx_chip) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_out <= 1'b0;
      code_oe  <= 1'b0;
    end else begin
      code_out <= nxt_code;
      code_oe  <= (nxt_code == code_out);
    end
  end

  // R9: disabled output goes low
  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !code_out);
  // R10: every change of the code is blanked
  p_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (code_out != $past(code_out)) |-> !code_oe);
endmodule

// File: rtl/dual_pn_gen.sv
module dual_pn_gen
  import pngen_pkg::*;
#(
  parameter int unsigned CHIP_DIV = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 is_master,
  input  logic                 ext_chip_en,
  input  logic                 tx_half,
  input  logic                 out_en,
  input  logic                 force_load,
  input  logic                 resync,
  input  logic [TAP_LO_W-1:0]  tx_tap_lo,
  input  logic [TAP_HI_W-1:0]  tx_tap_hi,
  input  logic [PN_MASK_W-1:0] tx_len_mask,
  input  logic [TAP_LO_W-1:0]  rx_tap_lo,
  input  logic [TAP_HI_W-1:0]  rx_tap_hi,
  input  logic [PN_MASK_W-1:0] rx_len_mask,
  output logic                 code_out,
  output logic                 code_oe,
  output logic                 tx_epoch,
  output logic                 rx_epoch
);
  localparam int unsigned NGEN = 2;   // index 0 = transmit, 1 = receive

  logic                 chip_stb;
  logic                 gen_adv   [NGEN];
  pn_word_t             gen_taps  [NGEN];
  logic [PN_MASK_W-1:0] gen_mask  [NGEN];
  logic                 gen_chip  [NGEN];
  logic                 gen_epoch [NGEN];
  logic                 tx_chip;
  logic                 rx_chip;

  pn_chip_div #(.DIV(CHIP_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (chip_stb)
  );

  assign gen_adv[0]  = is_master ? chip_stb : ext_chip_en;
  assign gen_adv[1]  = ext_chip_en;
  assign gen_taps[0] = {tx_tap_hi, tx_tap_lo};
  assign gen_taps[1] = {rx_tap_hi, rx_tap_lo};
  assign gen_mask[0] = tx_len_mask;
  assign gen_mask[1] = rx_len_mask;

  for (genvar gi = 0; gi < NGEN; gi++) begin : g_gen
    pn_lfsr u_lfsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (gen_adv[gi]),
      .resync     (resync),
      .force_load (force_load),
      .tap_in     (gen_taps[gi]),
      .mask_in    (gen_mask[gi]),
      .chip       (gen_chip[gi]),
      .epoch      (gen_epoch[gi])
    );
  end

  assign tx_chip  = gen_chip[0];
  assign rx_chip  = gen_chip[1];
  assign tx_epoch = gen_epoch[0];
  assign rx_epoch = gen_epoch[1];

  pn_out_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_half  (tx_half),
    .out_en   (out_en),
    .tx_chip  (tx_chip),
    .rx_chip  (rx_chip),
    .code_out (code_out),
    .code_oe  (code_oe)
  );

  // R8: transmit half carries the transmit chip
  p_mux_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && tx_half) |=> (code_out == $past(tx_chip)));
  // R8: receive half carries the receive chip
  p_mux_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !tx_half) |=> (code_out == $past(rx_chip)));
  // R11: resync puts both epochs up together
  p_epoch_resync_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (tx_epoch && rx_epoch));
endmodule

// File: tb/dual_pn_gen_tb.sv
module dual_pn_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1, ext_chip_en = 1'b0, tx_half = 1'b0, out_en = 1'b0;
  logic force_load = 1'b0, resync = 1'b0;
  logic [7:0] tx_tap_lo = '0, rx_tap_lo = '0, tx_len_mask = '0, rx_len_mask = '0;
  logic [4:0] tx_tap_hi = '0, rx_tap_hi = '0;
  logic code_out, code_oe, tx_epoch, rx_epoch;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string ph = "R1";

  always #4 clk = ~clk;  // 125 MHz

  dual_pn_gen u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .ext_chip_en(ext_chip_en),
    .tx_half(tx_half), .out_en(out_en), .force_load(force_load), .resync(resync),
    .tx_tap_lo(tx_tap_lo), .tx_tap_hi(tx_tap_hi), .tx_len_mask(tx_len_mask),
    .rx_tap_lo(rx_tap_lo), .rx_tap_hi(rx_tap_hi), .rx_len_mask(rx_len_mask),
    .code_out(code_out), .code_oe(code_oe), .tx_epoch(tx_epoch), .rx_epoch(rx_epoch)
  );

  // ---------------- independent model ----------------
  typedef struct packed { logic code; logic oe; } exp_t;
  exp_t sb_q[$];

  logic [12:0] m_st [2];
  logic [12:0] m_tap [2];
  logic [7:0]  m_mask [2];
  int          m_div;
  logic        m_last;

  function automatic logic [12:0] m_step(logic [12:0] s, logic [12:0] t, logic [7:0] mk);
    int top;
    logic fb, z;
    logic [12:0] r;
    top = 4;
    for (int i = 0; i < 8; i++) if (mk[i]) top = 5 + i;
    fb = 1'b0;
    for (int b = 0; b <= top; b++) if (t[b]) fb = fb ^ s[b];
    z = 1'b1;
    for (int b = 0; b < top; b++) if (s[b]) z = 1'b0;
    r = '0;
    for (int b = 1; b <= top; b++) r[b] = s[b-1];
    r[0] = fb ^ z;
    return r;
  endfunction

  always @(posedge clk) begin
    logic stb, nx;
    logic adv [2];
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        m_st[g] = 13'd1; m_tap[g] = '0; m_mask[g] = '0;
      end
      m_div = 0; m_last = 1'b0;
      sb_q.delete();
    end else begin
      stb = (m_div == 15);
      m_div = (m_div + 1) % 16;
      adv[0] = is_master ? stb : ext_chip_en;
      adv[1] = ext_chip_en;
      nx = out_en ? (tx_half ? m_st[0][0] : m_st[1][0]) : 1'b0;
      sb_q.push_back('{code: nx, oe: (nx == m_last)});
      m_last = nx;
      for (int g = 0; g < 2; g++) begin
        if (resync) m_st[g] = 13'd1;
        else if (adv[g]) m_st[g] = m_step(m_st[g], m_tap[g], m_mask[g]);
      end
      if (force_load) begin
        m_tap[0] = {tx_tap_hi, tx_tap_lo}; m_mask[0] = tx_len_mask;
        m_tap[1] = {rx_tap_hi, rx_tap_lo}; m_mask[1] = rx_len_mask;
      end
    end
  end

  // ---------------- monitor / scoreboard ----------------
  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", ph, what, act, exp);
    end
  endtask

  logic meas = 1'b0;
  logic prev_txe = 1'b0, prev_rxe = 1'b0;
  int   tx_rise = -1, rx_rise = -1;

  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(code_out == e.code, "code_out (R4/R8/R9)", code_out, e.code);
        chk(code_oe == e.oe, "code_oe (R10)", code_oe, e.oe);
      end
      chk(tx_epoch == (m_st[0] == 13'd1), "tx_epoch (R11)", tx_epoch, m_st[0] == 13'd1);
      chk(rx_epoch == (m_st[1] == 13'd1), "rx_epoch (R11)", rx_epoch, m_st[1] == 13'd1);
      if (meas) begin
        // R5: period 2^7 chips * 16 clocks for transmit, 2^13 * 1 for receive
        if (tx_epoch && !prev_txe) begin
          if (tx_rise >= 0) chk(cyc - tx_rise == 2048, "R5 tx period", cyc - tx_rise, 2048);
          tx_rise = cyc;
        end
        if (rx_epoch && !prev_rxe) begin
          if (rx_rise >= 0) chk(cyc - rx_rise == 8192, "R5 rx period", cyc - rx_rise, 8192);
          rx_rise = cyc;
        end
      end
      prev_txe = tx_epoch;
      prev_rxe = rx_epoch;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- driver ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int periods;
    tick(3);
    ph = "R1";
    chk(code_out == 1'b0, "R1 code_out in reset", code_out, 0);
    chk(code_oe == 1'b0, "R1 code_oe in reset", code_oe, 0);
    chk(tx_epoch && rx_epoch, "R1 epochs in reset", tx_epoch + rx_epoch, 2);

    rst_n = 1'b1;
    // transmit: x^7+x+1 recurrence, taps 7 and 6 -> lo bits 6,5; R7 mask 0x03
    tx_tap_lo = 8'h60; tx_tap_hi = 5'h00; tx_len_mask = 8'h03;
    // receive: taps 13,4,3,1 -> lo 0x0D, hi bit4; R13 mask 0xFF
    rx_tap_lo = 8'h0D; rx_tap_hi = 5'h10; rx_len_mask = 8'hFF;
    force_load = 1'b1; tick(1); force_load = 1'b0;
    ph = "R7"; resync = 1'b1; tick(1); resync = 1'b0;
    chk(tx_epoch && rx_epoch, "R7 both epochs after resync", tx_epoch + rx_epoch, 2);

    ph = "R2 master / R3 rx / R5 length";
    is_master = 1'b1; ext_chip_en = 1'b1; out_en = 1'b1;
    meas = 1'b1;
    for (int i = 0; i < 16700; i++) begin
      if (i % 37 == 0) tx_half = ~tx_half;
      tick(1);
    end
    meas = 1'b0;
    periods = checks;

    ph = "R2 slave / R3 rx / R8 mux";
    is_master = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      ext_chip_en = $urandom_range(0, 2) != 0;
      if (i % 23 == 0) tx_half = ~tx_half;
      tick(1);
    end

    ph = "R6 taps ignored without load";
    tx_tap_lo = 8'hA5; tx_tap_hi = 5'h1B; tx_len_mask = 8'hFF;
    rx_tap_lo = 8'h33; rx_tap_hi = 5'h04; rx_len_mask = 8'h07;
    for (int i = 0; i < 500; i++) begin
      ext_chip_en = $urandom_range(0, 1);
      tx_half = (i % 50) < 25;
      tick(1);
    end

    ph = "R6 force load / R4 new taps";
    // transmit: taps 9 and 5 -> lo bit4, hi bit0; R9 mask 0x0F
    tx_tap_lo = 8'h10; tx_tap_hi = 5'h01; tx_len_mask = 8'h0F;
    rx_tap_lo = 8'h60; rx_tap_hi = 5'h00; rx_len_mask = 8'h03;
    force_load = 1'b1; tick(1); force_load = 1'b0;
    ph = "R4 / R10 dense transitions";
    ext_chip_en = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      if (i % 41 == 0) tx_half = ~tx_half;
      tick(1);
    end

    ph = "R9 output disabled";
    out_en = 1'b0;
    for (int i = 0; i < 300; i++) begin
      tx_half = i[3];
      tick(1);
      chk(code_out == 1'b0, "R9 code_out low while disabled", code_out, 0);
    end
    out_en = 1'b1;

    ph = "R7 resync mid-run";
    tick(57);
    resync = 1'b1; tick(1); resync = 1'b0;
    chk(tx_epoch && rx_epoch, "R7 epochs after mid-run resync", tx_epoch + rx_epoch, 2);
    tick(200);

    if (periods == 0) chk(1'b0, "R5 no period measured", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule